// File: doc/BRIEF.md
# Supply-Loss Guard for Battery-Backed Static Memory

This block sits between a host and a static memory whose contents must outlive the main supply. Two external comparators report the supply level as plain flags. One flag says the supply has fallen into the power-fail window. The other says it has dropped further, below the point where storage must run from the backup cell. The guard synchronises both flags into its clock domain and gates the host's active-low chip and write enables before they reach the array. It forces the array's data drivers to high impedance and steers the storage supply to the battery when needed. It also reports whether access is currently being refused.

Once the supply comes back, protection is not released straight away. A recovery timer holds the array deselected for a fixed number of clock cycles, counted from the moment both synchronised flags read clear. A new dip during that hold restarts the count from the beginning. When a failure arrives in the middle of a write strobe, that strobe is cut in the same cycle in which protection rises. Only the location being written at that moment can therefore be damaged. Reset puts the block into the protected condition, and it then runs the same hold-off as a supply recovery.

Top module: `pwr_guard`

## Requirements
- R1: Each comparator flag passes through SYNC_STAGES flip-flops (default 2). A flag that rises at the pin shows on protect_o after exactly two rising edges, and not after one.
- R2: In any cycle where either synchronised flag is high, protect_o is 1 and both mem_ce_n_o and mem_we_n_o are 1.
- R3: While protect_o is 1, the host enables are ignored: mem_ce_n_o and mem_we_n_o stay 1 and out_hiz_o stays 1, whatever host_ce_n_i and host_we_n_i do.
- R4: With no protection in force, mem_ce_n_o equals host_ce_n_i and mem_we_n_o equals host_we_n_i in the same cycle. out_hiz_o is 1 exactly when host_ce_n_i is 1 or host_we_n_i is 0, and 0 for a read.
- R5: batt_sel_o becomes 1 on the rising edge after the synchronised below-switchover flag rises, which is three edges after the pin. It becomes 0 on the edge after that flag clears. The power-fail flag alone never selects the battery.
- R6: The below-switchover flag on its own, with the power-fail flag low, protects the memory just as a power failure does.
- R7: After both synchronised flags read clear, protect_o stays 1 for exactly TREC_CYCLES clock cycles and then falls to 0. This holds whether protection came from the power-fail flag or from battery operation.
- R8: A flag that reasserts during the recovery hold keeps protection up, and the full TREC_CYCLES count restarts once the flags clear again.
- R9: No active write strobe (mem_we_n_o = 0) is ever produced outside the normal state. A strobe that is active when a failure is detected ends in the cycle protect_o rises.
- R10: While rst_n is low, protect_o, out_hiz_o, mem_ce_n_o and mem_we_n_o are 1 and batt_sel_o is 0. After release, with both flags clear, protection lasts exactly TREC_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| supply_low_i | input | 1 | Asynchronous flag: supply inside the power-fail window |
| supply_crit_i | input | 1 | Asynchronous flag: supply below the battery-switchover threshold |
| host_ce_n_i | input | 1 | Host chip enable, active low |
| host_we_n_i | input | 1 | Host write enable, active low |
| mem_ce_n_o | output | 1 | Gated chip enable to the array, active low |
| mem_we_n_o | output | 1 | Gated write enable to the array, active low |
| out_hiz_o | output | 1 | 1 forces the array data drivers to high impedance |
| batt_sel_o | output | 1 | 1 powers storage from the backup cell |
| protect_o | output | 1 | 1 while host access is refused |

## Verification
The bench builds the guard with TREC_CYCLES set to 6 and SYNC_STAGES left at 2. With this short hold, each recovery window can be checked edge by edge, both the last protected cycle and the first open one. That includes the window after reset, after battery operation, and after a dip that restarts the count. The two-stage synchroniser gives a fixed pin-to-effect latency of two edges for protection and three for battery selection. Every expectation can therefore be placed on an exact cycle.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_PROTECT = 2'd1,
    ST_BATTERY = 2'd2,
    ST_RECOVER = 2'd3
  } guard_state_e;

  // bit positions of the comparator flags inside the synchroniser bus
  localparam int FLAG_LOW   = 0;
  localparam int FLAG_CRIT  = 1;
  localparam int NUM_FLAGS  = 2;

endpackage

// File: rtl/pwr_guard_sync.sv
module pwr_guard_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  // one independent flop chain per flag; STAGES must be 2 or more
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
      end
    end

    assign sync_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/pwr_guard_fsm.sv
module pwr_guard_fsm
  import pwr_guard_pkg::*;
#(
  parameter int TREC_CYCLES = 2000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         low_i,
  input  logic         crit_i,
  output guard_state_e state_o,
  output logic         fail_eff_o
);

  localparam int             CW   = (TREC_CYCLES < 2) ? 1 : $clog2(TREC_CYCLES + 1);
  localparam logic [CW-1:0]  LOAD = CW'(TREC_CYCLES - 1);

  guard_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fail_eff;

  // below-switchover without the power-fail flag still counts as failed
  assign fail_eff = low_i | crit_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (crit_i)        state_d = ST_BATTERY;
        else if (fail_eff) state_d = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (crit_i) begin
          state_d = ST_BATTERY;
        end else if (!fail_eff) begin
          if (LOAD == '0) state_d = ST_NORMAL;
          else begin
            state_d = ST_RECOVER;
            cnt_d   = LOAD;
          end
        end
      end
      ST_BATTERY: begin
        if (!crit_i) begin
          if (low_i) begin
            state_d = ST_PROTECT;
          end else if (LOAD == '0) begin
            state_d = ST_NORMAL;
          end else begin
            state_d = ST_RECOVER;
            cnt_d   = LOAD;
          end
        end
      end
      ST_RECOVER: begin
        if (crit_i) begin
          state_d = ST_BATTERY;
        end else if (fail_eff) begin
          state_d = ST_PROTECT;
        end else if (cnt_q <= CW'(1)) begin
          state_d = ST_NORMAL;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: state_d = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_PROTECT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o    = state_q;
  assign fail_eff_o = fail_eff;

endmodule

// File: rtl/pwr_guard_gate.sv
module pwr_guard_gate
  import pwr_guard_pkg::*;
(
  input  guard_state_e state_i,
  input  logic         fail_eff_i,
  input  logic         host_ce_n_i,
  input  logic         host_we_n_i,
  output logic         mem_ce_n_o,
  output logic         mem_we_n_o,
  output logic         out_hiz_o,
  output logic         batt_sel_o,
  output logic         protect_o
);

  logic open_q;

  // a fresh synchronised failure closes access before the state register moves
  assign open_q     = (state_i == ST_NORMAL) && !fail_eff_i;

  assign mem_ce_n_o = open_q ? host_ce_n_i : 1'b1;
  assign mem_we_n_o = open_q ? host_we_n_i : 1'b1;
  assign out_hiz_o  = !open_q || host_ce_n_i || !host_we_n_i;
  assign batt_sel_o = (state_i == ST_BATTERY);
  assign protect_o  = !open_q;

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pwr_guard_pkg::*;
#(
  parameter int TREC_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_low_i,
  input  logic supply_crit_i,
  input  logic host_ce_n_i,
  input  logic host_we_n_i,
  output logic mem_ce_n_o,
  output logic mem_we_n_o,
  output logic out_hiz_o,
  output logic batt_sel_o,
  output logic protect_o
);

  logic [NUM_FLAGS-1:0] flags_raw, flags_s;
  guard_state_e         state_w;
  logic                 fail_eff_w;
  logic                 crit_s_w;

  assign flags_raw[FLAG_LOW]  = supply_low_i;
  assign flags_raw[FLAG_CRIT] = supply_crit_i;
  assign crit_s_w             = flags_s[FLAG_CRIT];

  pwr_guard_sync #(
    .WIDTH  (NUM_FLAGS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (flags_raw),
    .sync_o  (flags_s)
  );

  pwr_guard_fsm #(
    .TREC_CYCLES (TREC_CYCLES)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .low_i      (flags_s[FLAG_LOW]),
    .crit_i     (flags_s[FLAG_CRIT]),
    .state_o    (state_w),
    .fail_eff_o (fail_eff_w)
  );

  pwr_guard_gate u_gate (
    .state_i     (state_w),
    .fail_eff_i  (fail_eff_w),
    .host_ce_n_i (host_ce_n_i),
    .host_we_n_i (host_we_n_i),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_we_n_o  (mem_we_n_o),
    .out_hiz_o   (out_hiz_o),
    .batt_sel_o  (batt_sel_o),
    .protect_o   (protect_o)
  );

endmodule

// File: rtl/pwr_guard_chk.sv
module pwr_guard_chk
  import pwr_guard_pkg::*;
#(
  parameter int TREC_CYCLES = 2000
) (
  input logic         clk,
  input logic         rst_n,
  input guard_state_e state_i,
  input logic         fail_eff_i,
  input logic         crit_i,
  input logic         mem_ce_n_o,
  input logic         mem_we_n_o,
  input logic         out_hiz_o,
  input logic         batt_sel_o,
  input logic         protect_o
);

  // cycles spent protected since the flags last read clear
  int run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          run_q <= 0;
    else if (fail_eff_i) run_q <= 0;
    else if (protect_o)  run_q <= run_q + 1;
    else                 run_q <= 0;
  end

  assert_fail_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fail_eff_i |-> (protect_o && mem_ce_n_o && mem_we_n_o));

  assert_hiz_while_protected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    protect_o |-> (out_hiz_o && mem_ce_n_o && mem_we_n_o));

  assert_batt_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    crit_i |=> batt_sel_o);

  assert_batt_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_i |=> !batt_sel_o);

  assert_crit_protects_R6: assert property (@(posedge clk) disable iff (!rst_n)
    crit_i |-> protect_o);

  assert_hold_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect_o) |-> (run_q == TREC_CYCLES));

  assert_dip_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_RECOVER && fail_eff_i) |=> (state_i == ST_PROTECT || state_i == ST_BATTERY));

  assert_no_strobe_outside_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != ST_NORMAL) |-> mem_we_n_o);

endmodule

bind pwr_guard pwr_guard_chk #(
  .TREC_CYCLES (TREC_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_i    (state_w),
  .fail_eff_i (fail_eff_w),
  .crit_i     (crit_s_w),
  .mem_ce_n_o (mem_ce_n_o),
  .mem_we_n_o (mem_we_n_o),
  .out_hiz_o  (out_hiz_o),
  .batt_sel_o (batt_sel_o),
  .protect_o  (protect_o)
);

// File: tb/pwr_guard_bench.sv
module pwr_guard_bench;

  localparam int T = 6;
  localparam int SIG_CE = 0, SIG_WE = 1, SIG_HIZ = 2, SIG_BATT = 3, SIG_PROT = 4;

  typedef struct {
    int    due;
    int    sig;
    logic  val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_low = 1'b0, supply_crit = 1'b0;
  logic host_ce_n = 1'b1, host_we_n = 1'b1;
  logic mem_ce_n, mem_we_n, out_hiz, batt_sel, protect;

  int   cyc_n  = 0;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  pwr_guard #(.TREC_CYCLES(T), .SYNC_STAGES(2)) u_pwr_guard (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_low_i  (supply_low),
    .supply_crit_i (supply_crit),
    .host_ce_n_i   (host_ce_n),
    .host_we_n_i   (host_we_n),
    .mem_ce_n_o    (mem_ce_n),
    .mem_we_n_o    (mem_we_n),
    .out_hiz_o     (out_hiz),
    .batt_sel_o    (batt_sel),
    .protect_o     (protect)
  );

  function automatic logic sig_val(int s);
    case (s)
      SIG_CE:   return mem_ce_n;
      SIG_WE:   return mem_we_n;
      SIG_HIZ:  return out_hiz;
      SIG_BATT: return batt_sel;
      default:  return protect;
    endcase
  endfunction

  function automatic string sig_name(int s);
    case (s)
      SIG_CE:   return "mem_ce_n";
      SIG_WE:   return "mem_we_n";
      SIG_HIZ:  return "out_hiz";
      SIG_BATT: return "batt_sel";
      default:  return "protect";
    endcase
  endfunction

  task automatic check_now(int s, logic v, string tag);
    logic got;
    got = sig_val(s);
    checks++;
    if (got !== v) begin
      fails++;
      $display("FAIL %s cycle %0d %s actual=%b expected=%b", tag, cyc_n, sig_name(s), got, v);
    end
  endtask

  // driver side: queue an expectation d negedges from now
  task automatic expect_at(int d, int s, logic v, string tag);
    exp_t e;
    e.due = cyc_n + d;
    e.sig = s;
    e.val = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor side: compare due expectations half a cycle after each edge
  always @(negedge clk) begin
    cyc_n++;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc_n) begin
        check_now(q[i].sig, q[i].val, q[i].tag);
        q.delete(i);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    settle(3);
    // R10: state held during reset
    check_now(SIG_PROT, 1'b1, "R10");
    check_now(SIG_HIZ,  1'b1, "R10");
    check_now(SIG_CE,   1'b1, "R10");
    check_now(SIG_WE,   1'b1, "R10");
    check_now(SIG_BATT, 1'b0, "R10");
    rst_n = 1'b1;
    expect_at(T,     SIG_PROT, 1'b1, "R10");
    expect_at(T + 1, SIG_PROT, 1'b0, "R10");
    settle(T + 3);

    // R4: pass-through in normal operation
    host_ce_n = 1'b0; host_we_n = 1'b1;
    expect_at(1, SIG_CE, 1'b0, "R4");
    expect_at(1, SIG_WE, 1'b1, "R4");
    expect_at(1, SIG_HIZ, 1'b0, "R4");
    settle(2);
    host_we_n = 1'b0;
    expect_at(1, SIG_WE, 1'b0, "R4");
    expect_at(1, SIG_HIZ, 1'b1, "R4");
    settle(2);
    host_ce_n = 1'b1; host_we_n = 1'b1;
    expect_at(1, SIG_CE, 1'b1, "R4");
    expect_at(1, SIG_HIZ, 1'b1, "R4");
    settle(2);

    // R1, R2, R9: failure in the middle of a write strobe
    host_ce_n = 1'b0; host_we_n = 1'b0;
    settle(1);
    supply_low = 1'b1;
    expect_at(2, SIG_WE,   1'b0, "R1");
    expect_at(2, SIG_PROT, 1'b0, "R1");
    expect_at(3, SIG_WE,   1'b1, "R9");
    expect_at(3, SIG_PROT, 1'b1, "R2");
    expect_at(3, SIG_CE,   1'b1, "R2");
    expect_at(3, SIG_HIZ,  1'b1, "R2");
    settle(4);

    // R3: host toggling ignored while protected
    host_we_n = 1'b1;
    expect_at(1, SIG_CE,  1'b1, "R3");
    expect_at(1, SIG_HIZ, 1'b1, "R3");
    settle(2);
    host_we_n = 1'b0;
    expect_at(1, SIG_WE, 1'b1, "R3");
    settle(2);

    // R7: exact recovery hold
    supply_low = 1'b0;
    expect_at(2 + T, SIG_PROT, 1'b1, "R7");
    expect_at(2 + T, SIG_WE,   1'b1, "R7");
    expect_at(3 + T, SIG_PROT, 1'b0, "R7");
    expect_at(3 + T, SIG_WE,   1'b0, "R7");
    settle(T + 5);

    // R8: dip during recovery restarts the count
    supply_low = 1'b1;
    settle(5);
    supply_low = 1'b0;
    settle(4);
    supply_low = 1'b1;
    expect_at(2, SIG_PROT, 1'b1, "R8");
    settle(4);
    supply_low = 1'b0;
    expect_at(2 + T, SIG_PROT, 1'b1, "R8");
    expect_at(3 + T, SIG_PROT, 1'b0, "R8");
    settle(T + 5);

    // R5: battery switchover and return
    supply_low = 1'b1; supply_crit = 1'b1;
    expect_at(3, SIG_PROT, 1'b1, "R5");
    expect_at(3, SIG_BATT, 1'b0, "R5");
    expect_at(4, SIG_BATT, 1'b1, "R5");
    settle(6);
    supply_crit = 1'b0;
    expect_at(3, SIG_BATT, 1'b1, "R5");
    expect_at(4, SIG_BATT, 1'b0, "R5");
    expect_at(4, SIG_PROT, 1'b1, "R5");
    settle(6);
    supply_low = 1'b0;
    expect_at(2 + T, SIG_PROT, 1'b1, "R7");
    expect_at(3 + T, SIG_PROT, 1'b0, "R7");
    expect_at(3 + T, SIG_BATT, 1'b0, "R5");
    settle(T + 5);

    // R6: switchover flag alone
    supply_crit = 1'b1;
    expect_at(3, SIG_PROT, 1'b1, "R6");
    expect_at(3, SIG_WE,   1'b1, "R6");
    expect_at(4, SIG_BATT, 1'b1, "R6");
    settle(6);
    supply_crit = 1'b0;
    expect_at(4,     SIG_BATT, 1'b0, "R6");
    expect_at(2 + T, SIG_PROT, 1'b1, "R6");
    expect_at(3 + T, SIG_PROT, 1'b0, "R6");
    settle(T + 5);

    while (q.size() != 0) settle(1);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule